// File: doc/BRIEF.md
# Bidirectional Open-Drain Line Repeater

This block joins two open-drain data wires, one facing a card and one facing a host controller. Both wires rest high through pull-ups and either end may pull its own wire low. The block samples both wires. Whichever wire falls first becomes the master, and the block copies that low onto the other wire, the slave, after a fixed delay. While the master wire is held low, the block ignores falls on the slave wire. When the master lets go, the block releases its pull-down on the slave and turns on a short active pull-up. This gives a fast rising edge on a loaded wire. The block accepts a new transfer only after both wires are seen high again.

The outputs are four registered enables, a pull-down and a pull-up for each side, meant for the pad drivers. The enable input models a card session. While it is low nothing is driven and no falls are acted upon. The delay is given in clock cycles. At a 100 MHz clock, the default of 20 cycles is about 200 ns, which fits line rates up to 1 MHz.

Top module: `od_line_repeater`

## Requirements
- R1: After reset, and whenever no transfer is in progress, all four drive enables are 0.
- R2: A fall on one wire while idle and enabled makes that wire master. The other wire's pull-down enable rises exactly SYNC_STAGES+1+EDGE_DLY clock edges after the first edge that samples the low level.
- R3: While a transfer is in progress, a fall on the slave wire does not change the master. The master wire is never driven.
- R4: If both wires fall in the same sample, the card wire becomes master and the host wire is pulled low.
- R5: When the master wire returns high, the slave pull-down drops and the slave pull-up rises on the same edge, SYNC_STAGES+1 edges after the first edge that samples the high level. The pull-up then stays on for exactly EDGE_DLY cycles.
- R6: On a given side, the pull-down and pull-up enables are never both 1. The two sides are never driven at once.
- R7: With enable low, all drive enables are 0 from the next clock edge, even in mid-transfer. Falls seen while enable is low start nothing.
- R8: If the master wire returns high before the delay has elapsed, the slave wire is never driven.
- R9: After the pull-up pulse, the block waits until both wires are sampled high. Falls that happen before that start no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Session enable; low forces everything idle |
| card_in | input | 1 | Sampled level of the card-side wire |
| host_in | input | 1 | Sampled level of the host-side wire |
| card_drv_lo | output | 1 | Pull-down enable for the card wire |
| card_drv_hi | output | 1 | Active pull-up enable for the card wire |
| host_drv_lo | output | 1 | Pull-down enable for the host wire |
| host_drv_hi | output | 1 | Active pull-up enable for the host wire |

## Verification
The bench models each wire as a wired-AND of the block's pull-down and an external pull-down. It aims at the cases where a design can go wrong:
- a late fall on the slave wire, which a design without suppression would turn into a second master and a latched-low pair;
- simultaneous falls, where a design with the wrong priority drives the card wire;
- a master glitch shorter than the delay, which a design without abort would answer with a stray low pulse;
- a fall during the settle wait, which a design that re-arms early would copy.

Disabling in mid-hold checks that the drives drop on the next edge and are not left held. The exact copy latency and the exact pull-up length are compared cycle by cycle, so an off-by-one in either delay is reported.

// File: rtl/lr_pkg.sv
package lr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_HOLD,
    ST_PULSE,
    ST_SETTLE
  } lr_state_t;

  typedef enum logic {
    SIDE_CARD = 1'b0,
    SIDE_HOST = 1'b1
  } lr_side_t;
endpackage

// File: rtl/lr_sync.sv
module lr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) ff <= 1'b1;
        else     ff <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) ff <= '1;
        else     ff <= {ff[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = ff[STAGES-1];
endmodule

// File: rtl/lr_timer.sv
module lr_timer #(
  parameter int DLY = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic done
);
  localparam int CW = (DLY < 2) ? 1 : $clog2(DLY);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (load)          cnt <= CW'(DLY - 1);
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/lr_ctrl.sv
module lr_ctrl
  import lr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic s_card,
  input  logic s_host,
  input  logic tmr_done,
  output logic tmr_load,
  output logic card_drv_lo,
  output logic card_drv_hi,
  output logic host_drv_lo,
  output logic host_drv_hi
);
  lr_state_t state, state_n;
  lr_side_t  side, side_n;
  logic      prev_card, prev_host;
  logic      fall_card, fall_host, master_high;

  assign fall_card   = prev_card & ~s_card;
  assign fall_host   = prev_host & ~s_host;
  assign master_high = (side == SIDE_CARD) ? s_card : s_host;

  always_comb begin
    state_n = state;
    side_n  = side;
    if (!en) begin
      state_n = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (fall_card) begin
            state_n = ST_WAIT;
            side_n  = SIDE_CARD;
          end else if (fall_host) begin
            state_n = ST_WAIT;
            side_n  = SIDE_HOST;
          end
        end
        ST_WAIT: begin
          if (master_high)   state_n = ST_SETTLE;
          else if (tmr_done) state_n = ST_HOLD;
        end
        ST_HOLD:   if (master_high)       state_n = ST_PULSE;
        ST_PULSE:  if (tmr_done)          state_n = ST_SETTLE;
        ST_SETTLE: if (s_card && s_host)  state_n = ST_IDLE;
        default:   state_n = ST_IDLE;
      endcase
    end
  end

  assign tmr_load = ((state_n == ST_WAIT)  && (state != ST_WAIT)) ||
                    ((state_n == ST_PULSE) && (state != ST_PULSE));

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      side        <= SIDE_CARD;
      prev_card   <= 1'b1;
      prev_host   <= 1'b1;
      card_drv_lo <= 1'b0;
      card_drv_hi <= 1'b0;
      host_drv_lo <= 1'b0;
      host_drv_hi <= 1'b0;
    end else begin
      state       <= state_n;
      side        <= side_n;
      prev_card   <= s_card;
      prev_host   <= s_host;
      card_drv_lo <= (state_n == ST_HOLD)  && (side_n == SIDE_HOST);
      card_drv_hi <= (state_n == ST_PULSE) && (side_n == SIDE_HOST);
      host_drv_lo <= (state_n == ST_HOLD)  && (side_n == SIDE_CARD);
      host_drv_hi <= (state_n == ST_PULSE) && (side_n == SIDE_CARD);
    end
  end
endmodule

// File: rtl/od_line_repeater.sv
module od_line_repeater #(
  parameter int EDGE_DLY    = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic card_in,
  input  logic host_in,
  output logic card_drv_lo,
  output logic card_drv_hi,
  output logic host_drv_lo,
  output logic host_drv_hi
);
  logic s_card, s_host;
  logic tmr_load, tmr_done;

  lr_sync #(.STAGES(SYNC_STAGES)) u_sync_card (
    .clk(clk), .rst(rst), .d(card_in), .q(s_card)
  );

  lr_sync #(.STAGES(SYNC_STAGES)) u_sync_host (
    .clk(clk), .rst(rst), .d(host_in), .q(s_host)
  );

  lr_timer #(.DLY(EDGE_DLY)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .done(tmr_done)
  );

  lr_ctrl u_ctrl (
    .clk(clk), .rst(rst), .en(en),
    .s_card(s_card), .s_host(s_host),
    .tmr_done(tmr_done), .tmr_load(tmr_load),
    .card_drv_lo(card_drv_lo), .card_drv_hi(card_drv_hi),
    .host_drv_lo(host_drv_lo), .host_drv_hi(host_drv_hi)
  );
endmodule

// File: rtl/lr_checker.sv
module lr_checker #(
  parameter int DLY = 20
) (
  input logic clk,
  input logic rst,
  input logic en,
  input logic card_drv_lo,
  input logic card_drv_hi,
  input logic host_drv_lo,
  input logic host_drv_hi
);
  logic [31:0] card_run, host_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      card_run <= '0;
      host_run <= '0;
    end else begin
      card_run <= card_drv_hi ? card_run + 1 : '0;
      host_run <= host_drv_hi ? host_run + 1 : '0;
    end
  end

  AST_CARD_LO_HI_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(card_drv_lo && card_drv_hi)); // R6
  AST_HOST_LO_HI_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(host_drv_lo && host_drv_hi)); // R6
  AST_ONE_SIDE_ONLY: assert property (@(posedge clk) disable iff (rst)
    !((card_drv_lo || card_drv_hi) && (host_drv_lo || host_drv_hi))); // R3
  AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (rst)
    !en |=> !(card_drv_lo || card_drv_hi || host_drv_lo || host_drv_hi)); // R7
  AST_CARD_PULSE_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(card_drv_hi) |-> $past(card_drv_lo)); // R5
  AST_HOST_PULSE_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(host_drv_hi) |-> $past(host_drv_lo)); // R5
  AST_CARD_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
    card_drv_hi |-> (card_run < 32'(DLY))); // R5
  AST_HOST_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
    host_drv_hi |-> (host_run < 32'(DLY))); // R5
endmodule

bind od_line_repeater lr_checker #(.DLY(EDGE_DLY)) u_chk (
  .clk(clk), .rst(rst), .en(en),
  .card_drv_lo(card_drv_lo), .card_drv_hi(card_drv_hi),
  .host_drv_lo(host_drv_lo), .host_drv_hi(host_drv_hi)
);

// File: tb/od_line_repeater_tb.sv
module od_line_repeater_tb;
  localparam int D   = 4;
  localparam int SY  = 2;
  localparam int LAT = SY + 1 + D;

  typedef struct {
    int       cyc;
    logic [3:0] vec;
    string    req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic card_ext = 1'b0;
  logic host_ext = 1'b0;
  logic card_in, host_in;
  logic card_drv_lo, card_drv_hi, host_drv_lo, host_drv_hi;
  logic [3:0] drv;
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  exp_t sb[$];

  localparam logic [3:0] V_NONE = 4'b0000;
  localparam logic [3:0] V_CLO  = 4'b1000;
  localparam logic [3:0] V_CHI  = 4'b0100;
  localparam logic [3:0] V_HLO  = 4'b0010;
  localparam logic [3:0] V_HHI  = 4'b0001;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign card_in = ~(card_drv_lo | card_ext);
  assign host_in = ~(host_drv_lo | host_ext);
  assign drv = {card_drv_lo, card_drv_hi, host_drv_lo, host_drv_hi};

  od_line_repeater #(.EDGE_DLY(D), .SYNC_STAGES(SY)) u_dut (
    .clk(clk), .rst(rst), .en(en),
    .card_in(card_in), .host_in(host_in),
    .card_drv_lo(card_drv_lo), .card_drv_hi(card_drv_hi),
    .host_drv_lo(host_drv_lo), .host_drv_hi(host_drv_hi)
  );

  task automatic check_now(input logic [3:0] exp, input string req);
    checks++;
    if (drv !== exp) begin
      fails++;
      $display("FAIL %s cyc=%0d drives actual=%b expected=%b", req, cyc, drv, exp);
    end
  endtask

  task automatic push(input int c, input logic [3:0] v, input string req);
    exp_t e;
    e.cyc = c; e.vec = v; e.req = req;
    sb.push_back(e);
  endtask

  // monitor: pops scheduled expectations when their cycle arrives
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (e.cyc < cyc) begin
        fails++;
        $display("FAIL %s missed cycle actual=%0d expected=%0d", e.req, cyc, e.cyc);
      end else if (drv !== e.vec) begin
        fails++;
        $display("FAIL %s cyc=%0d drives actual=%b expected=%b", e.req, cyc, drv, e.vec);
      end
    end
  end

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
  endtask

  // full transfer: master pulls low, holds, releases; slave copies
  task automatic transfer(input bit host_master, input int hold);
    logic [3:0] slo, shi;
    int c0, c1;
    slo = host_master ? V_CLO : V_HLO;
    shi = host_master ? V_CHI : V_HHI;
    @(negedge clk);
    c0 = cyc;
    if (host_master) host_ext = 1'b1; else card_ext = 1'b1;
    push(c0 + LAT - 1, V_NONE, "R2");
    push(c0 + LAT,     slo,    "R2");
    idle_cycles(LAT + hold);
    c1 = cyc;
    if (host_master) host_ext = 1'b0; else card_ext = 1'b0;
    push(c1 + SY,         slo,    "R5");
    push(c1 + SY + 1,     shi,    "R5");
    push(c1 + SY + D,     shi,    "R5");
    push(c1 + SY + 1 + D, V_NONE, "R5");
    drain();
    idle_cycles(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_now(V_NONE, "R1 in reset");
    rst = 1'b0;
    idle_cycles(3);
    check_now(V_NONE, "R1 after reset");
    en = 1'b1;
    idle_cycles(3);
    check_now(V_NONE, "R1 idle enabled");

    // R2/R5: host master, then card master
    transfer(1'b1, 5);
    transfer(1'b0, 2);
    check_now(V_NONE, "R1 idle after transfers");

    // R3: host master, card falls later; card must not claim, host never driven
    begin
      int c0, c1;
      @(negedge clk);
      c0 = cyc;
      host_ext = 1'b1;
      push(c0 + LAT, V_CLO, "R3");
      idle_cycles(2);
      card_ext = 1'b1;
      idle_cycles(LAT + 3);
      check_now(V_CLO, "R3 slave fall ignored");
      c1 = cyc;
      host_ext = 1'b0;
      push(c1 + SY + 1,     V_CHI,  "R3");
      push(c1 + SY + 1 + D, V_NONE, "R3");
      drain();
      // R9: card still low, block waits; a host fall now starts nothing
      host_ext = 1'b1;
      for (int i = 0; i < LAT + 4; i++) begin
        @(negedge clk);
        check_now(V_NONE, "R9 no transfer before both high");
      end
      host_ext = 1'b0;
      card_ext = 1'b0;
      idle_cycles(5);
      check_now(V_NONE, "R9 idle after release");
    end
    transfer(1'b1, 1);

    // R4: both fall together, card wins
    begin
      int c0, c1;
      @(negedge clk);
      c0 = cyc;
      card_ext = 1'b1;
      host_ext = 1'b1;
      push(c0 + LAT, V_HLO, "R4");
      idle_cycles(LAT + 2);
      c1 = cyc;
      card_ext = 1'b0;
      push(c1 + SY + 1, V_HHI, "R4");
      drain();
      host_ext = 1'b0;
      idle_cycles(LAT + 4);
      check_now(V_NONE, "R4 back to idle");
    end

    // R8: short master glitch, slave never driven
    @(negedge clk);
    card_ext = 1'b1;
    idle_cycles(2);
    card_ext = 1'b0;
    for (int i = 0; i < LAT + 6; i++) begin
      @(negedge clk);
      check_now(V_NONE, "R8 short low not copied");
    end
    transfer(1'b0, 3);

    // R7: disable in mid-hold
    begin
      int c0;
      @(negedge clk);
      host_ext = 1'b1;
      idle_cycles(LAT + 2);
      check_now(V_CLO, "R7 holding before disable");
      c0 = cyc;
      en = 1'b0;
      push(c0 + 1, V_NONE, "R7");
      drain();
      idle_cycles(3);
      host_ext = 1'b0;
      idle_cycles(4);
      check_now(V_NONE, "R7 disabled idle");
      // falls while disabled are ignored
      card_ext = 1'b1;
      for (int i = 0; i < LAT + 4; i++) begin
        @(negedge clk);
        check_now(V_NONE, "R7 fall ignored when disabled");
      end
      card_ext = 1'b0;
      idle_cycles(4);
      en = 1'b1;
      idle_cycles(LAT + 2);
      check_now(V_NONE, "R7 no late action after enable");
    end
    transfer(1'b1, 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule